// File: doc/BRIEF.md
# DQPSK Differential Decoder and Bit Serializer

This block sits behind a pair of quadrature data slicers in a digital sound receiver. Once per symbol it takes the slicers' 2-bit quadrant decision, works out the phase change from the symbol before, and turns that change back into the transmitted bit pair. Each pair is then shifted out as two serial bits at the bit rate, most significant bit first.

All timing comes from one master clock running at eight times the bit rate (nominally 5.824 MHz against a 728 kHz bit rate). A divider produces a single-cycle bit strobe every eight master cycles and a square bit clock for export. Every second bit strobe is also a symbol strobe, which gives the half-rate 364 kHz symbol timing that clocks the differential decoder. No other clock is created: every register runs on the master clock and advances on these enables.

The carrier loop's lock status arrives as an input. The active-low mute output follows it, so downstream stages are muted whenever no coherent data can be recovered.

Top module: `dqpsk_diff_serializer`

## Requirements
- R1: `bit_stb` is high for exactly one master cycle in every eight. After reset is released, its first high cycle is the eighth master cycle, which is counted from the first rising edge with `rst_n` high (cycle index 7, counting from 0).
- R2: `bit_clk` is high in the four master cycles that end with, and include, each `bit_stb` cycle. It is low in the other four cycles of each bit period.
- R3: `sym_stb` is high only together with every second `bit_stb` (the 2nd, 4th, and so on after reset). The quadrant input `quad_in` is sampled at the clock edge that ends each `sym_stb` cycle.
- R4: The quadrant code on `quad_in` is the phase divided by 90 degrees. For each sampled symbol, step = (current − previous) mod 4. Steps 0, 1, 2 and 3 decode to the bit pairs 00, 01, 11 and 10.
- R5: Reset clears the stored previous quadrant to 0. The first symbol after reset is therefore decoded against quadrant 0.
- R6: The pair decoded at symbol strobe k appears on `ser_data` as follows. Its first bit (the left bit as written in R4) appears after the next `bit_stb`. Its second bit appears after the `bit_stb` after that. `ser_data` changes only in the cycle following a `bit_stb`.
- R7: `mute_n` is low during reset. Otherwise it equals the value `lock_in` had one master cycle earlier.
- R8: `ser_data` is 0 during reset and stays 0 until the first decoded pair is shifted out.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, eight times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| quad_in | input | 2 | Quadrant decision from the slicers (phase/90) |
| lock_in | input | 1 | Carrier loop lock indication, high when locked |
| ser_data | output | 1 | Recovered serial bit stream |
| bit_clk | output | 1 | Exported square bit clock |
| bit_stb | output | 1 | One-cycle bit-rate enable |
| sym_stb | output | 1 | One-cycle symbol-rate enable (half bit rate) |
| mute_n | output | 1 | Active-low mute, low when the loop is unlocked |

## Verification
The bench targets several corner cases. The first is the modulo-4 wrap of the phase step. Backward steps such as 0 to 3 and 1 to 0 must give 10 and 10, not a negative index; a decoder that subtracts without wrapping would emit wrong pairs there. The second is the first symbol after a reset issued in mid-stream, when the previous quadrant was non-zero. A design that fails to clear the history register decodes that symbol against stale data. The bench also checks bit order and latency on every strobe, so a swapped pair or a one-bit-period slip shows up at once. The lock input is toggled at random, which catches a mute that is inverted or delayed by more than one cycle.

// File: rtl/dqpsk_pkg.sv
package dqpsk_pkg;

  // Quadrant code and decoded pair widths for four-phase keying
  localparam int QUAD_W = 2;
  localparam int PAIR_W = 2;

  typedef logic [QUAD_W-1:0] quad_t;
  typedef logic [PAIR_W-1:0] pair_t;

  // Phase advance between two symbols, in quarter turns, modulo 4
  function automatic quad_t phase_step(input quad_t cur, input quad_t prev);
    quad_t d;
    d = cur - prev;
    return d;
  endfunction

  // Gray mapping of the quarter-turn advance onto the transmitted pair
  function automatic pair_t step_to_pair(input quad_t step);
    pair_t p;
    case (step)
      2'd0:    p = 2'b00;
      2'd1:    p = 2'b01;
      2'd2:    p = 2'b11;
      default: p = 2'b10;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dqpsk_clkdiv.sv
module dqpsk_clkdiv #(
  parameter int BIT_DIV      = 8,
  parameter int BITS_PER_SYM = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  output logic                            bit_en,
  output logic                            sym_en,
  output logic                            bit_clk,
  output logic [$clog2(BITS_PER_SYM)-1:0] slot
);

  localparam int CW   = $clog2(BIT_DIV);
  localparam int SW   = $clog2(BITS_PER_SYM);
  localparam int HALF = BIT_DIV / 2;

  logic [CW-1:0] cnt_q;
  logic [SW-1:0] slot_q;
  logic          last_slot;

  assign bit_en    = (cnt_q == CW'(BIT_DIV - 1));
  assign bit_clk   = (cnt_q >= CW'(HALF));
  assign last_slot = (slot_q == SW'(BITS_PER_SYM - 1));
  assign sym_en    = bit_en && last_slot;
  assign slot      = slot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      slot_q <= '0;
    end else if (bit_en) begin
      cnt_q  <= '0;
      slot_q <= last_slot ? '0 : slot_q + SW'(1);
    end else begin
      cnt_q  <= cnt_q + CW'(1);
    end
  end

  AST_BIT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_en); // R1
  AST_BITCLK_AT_STB: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |-> bit_clk); // R2
  AST_BITCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> !bit_clk); // R2
  AST_SYM_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sym_en |-> bit_en); // R3

endmodule

// File: rtl/dqpsk_diff_dec.sv
module dqpsk_diff_dec
  import dqpsk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_en,
  input  quad_t quad_in,
  output pair_t pair,
  output quad_t step
);

  quad_t prev_q;
  pair_t pair_q;

  assign step = phase_step(quad_in, prev_q);
  assign pair = pair_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      pair_q <= '0;
    end else if (sym_en) begin
      prev_q <= quad_in;
      pair_q <= step_to_pair(step);
    end
  end

  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sym_en |=> $stable(pair_q)); // R3
  AST_PREV_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    sym_en |=> prev_q == $past(quad_in)); // R5
  AST_SAME_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && quad_in == prev_q) |=> pair_q == 2'b00); // R4
  AST_HALF_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_en && (quad_in ^ prev_q) == 2'b10) |=> pair_q == 2'b11); // R4

endmodule

// File: rtl/dqpsk_p2s.sv
module dqpsk_p2s #(
  parameter int PAIR_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_en,
  input  logic [$clog2(PAIR_W)-1:0] slot,
  input  logic [PAIR_W-1:0]         pair,
  output logic                      ser
);

  localparam int SW = $clog2(PAIR_W);

  logic [SW-1:0] pick;
  logic          ser_q;

  // Slot 0 takes the leftmost bit, so the pair leaves first bit first
  assign pick = SW'(PAIR_W - 1) - slot;
  assign ser  = ser_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ser_q <= 1'b0;
    else if (bit_en) ser_q <= pair[pick];
  end

  AST_SER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_q)); // R6

endmodule

// File: rtl/dqpsk_diff_serializer.sv
module dqpsk_diff_serializer
  import dqpsk_pkg::*;
#(
  parameter int BIT_DIV = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] quad_in,
  input  logic       lock_in,
  output logic       ser_data,
  output logic       bit_clk,
  output logic       bit_stb,
  output logic       sym_stb,
  output logic       mute_n
);

  localparam int SW = $clog2(PAIR_W);

  logic          bit_en;
  logic          sym_en;
  logic [SW-1:0] slot;
  pair_t         pair;
  quad_t         step;
  logic          mute_q;

  dqpsk_clkdiv #(
    .BIT_DIV      (BIT_DIV),
    .BITS_PER_SYM (PAIR_W)
  ) clkdiv_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .sym_en  (sym_en),
    .bit_clk (bit_clk),
    .slot    (slot)
  );

  dqpsk_diff_dec dec_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_en  (sym_en),
    .quad_in (quad_in),
    .pair    (pair),
    .step    (step)
  );

  dqpsk_p2s #(
    .PAIR_W (PAIR_W)
  ) p2s_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .slot   (slot),
    .pair   (pair),
    .ser    (ser_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) mute_q <= 1'b0;
    else        mute_q <= lock_in;
  end

  assign mute_n  = mute_q;
  assign bit_stb = bit_en;
  assign sym_stb = sym_en;

  AST_MUTE_ON_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_in |=> !mute_n); // R7
  AST_UNMUTE_ON_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    lock_in |=> mute_n); // R7
  AST_SER_ONLY_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(ser_data)); // R6

endmodule

// File: tb/dqpsk_diff_serializer_tb.sv
module dqpsk_diff_serializer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] quad_in;
  logic       lock_in;
  logic       ser_data, bit_clk, bit_stb, sym_stb, mute_n;

  always #2 clk = ~clk;

  dqpsk_diff_serializer dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .quad_in  (quad_in),
    .lock_in  (lock_in),
    .ser_data (ser_data),
    .bit_clk  (bit_clk),
    .bit_stb  (bit_stb),
    .sym_stb  (sym_stb),
    .mute_n   (mute_n)
  );

  int n_run  = 0;
  int n_fail = 0;

  // Bench model state
  int         cyc;
  int         strobes;
  int         syms;
  logic [1:0] prev_m;
  logic [1:0] pair_m;
  logic       exp_ser;
  logic       lock_m;
  int         dq[$];

  function automatic logic [1:0] tb_pair(input logic [1:0] cur, input logic [1:0] prev);
    int adv;
    logic [1:0] lut [4];
    lut[0] = 2'b00; lut[1] = 2'b01; lut[2] = 2'b11; lut[3] = 2'b10;
    adv = (int'(cur) + 4 - int'(prev)) % 4;
    return lut[adv];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  function automatic logic [1:0] next_quad();
    logic [1:0] v;
    if (dq.size() > 0) v = 2'(dq.pop_front());
    else               v = 2'($urandom % 4);
    return v;
  endfunction

  task automatic load_directed();
    // covers every forward and backward step, including wraps
    dq = '{2, 2, 3, 0, 1, 3, 1, 0, 3, 2, 0, 0, 1, 2, 0, 3};
  endtask

  task automatic do_reset();
    rst_n   = 1'b0;
    lock_in = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(mute_n == 1'b0, "R7", int'(mute_n), 0);
      chk(ser_data == 1'b0, "R8", int'(ser_data), 0);
      chk(bit_stb == 1'b0, "R1", int'(bit_stb), 0);
    end
    rst_n   = 1'b1;
    cyc     = 0;
    strobes = 0;
    syms    = 0;
    prev_m  = 2'd0;
    pair_m  = 2'd0;
    exp_ser = 1'b0;
    lock_m  = 1'b0;
  endtask

  task automatic step_cycle();
    bit exp_stb;
    exp_stb = (cyc % 8) == 7;
    chk(bit_stb == exp_stb, "R1", int'(bit_stb), int'(exp_stb));
    chk(bit_clk == ((cyc % 8) >= 4), "R2", int'(bit_clk), int'((cyc % 8) >= 4));
    chk(sym_stb == ((cyc % 16) == 15), "R3", int'(sym_stb), int'((cyc % 16) == 15));
    if (strobes < 2) chk(ser_data == exp_ser, "R8", int'(ser_data), int'(exp_ser));
    else if (syms <= 1) chk(ser_data == exp_ser, "R5", int'(ser_data), int'(exp_ser));
    else chk(ser_data == exp_ser, "R6", int'(ser_data), int'(exp_ser));
    chk(mute_n == lock_m, "R7", int'(mute_n), int'(lock_m));
    if (exp_stb) begin
      strobes++;
      if (strobes % 2 == 1) begin
        exp_ser = pair_m[1];
        quad_in = next_quad();
      end else begin
        exp_ser = pair_m[0];
        pair_m  = tb_pair(quad_in, prev_m); // R4 mapping
        prev_m  = quad_in;
        syms++;
      end
    end
    if (($urandom % 24) == 0) lock_in = ~lock_in;
    lock_m = lock_in;
    cyc++;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    quad_in = 2'd0;
    load_directed();
    do_reset();
    repeat (3000) step_cycle();
    // mid-stream reset with a non-zero history: first symbol must use quadrant 0 (R5)
    load_directed();
    do_reset();
    repeat (3000) step_cycle();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule